// File: doc/BRIEF.md
# Windowed Down Pitch Shifter

This block lowers the pitch of a mono stream of signed PCM samples while keeping its duration and sample timing. The stream is cut into consecutive windows of `WIN` samples. Each window is written into one bank of a two-bank buffer while the previous window is read back from the other bank. The read side covers only the leading three quarters of the stored window, and it spreads them over the whole window period. The waveform is stretched by 4/3 and its pitch drops to 3/4.

The read position is a fixed-point accumulator in quarter-sample units. It advances by three quarters for each output sample. Each output is a linear blend of the two stored samples around that position, so the block produces exactly one output for every input strobe. The output trails the input by one window plus two clock cycles. Outputs stay at zero until the first window has been captured.

Top module: `pshift_down`

## Requirements
- R1: For every cycle with `valid_i` high, `valid_o` is high exactly two clock cycles later. `valid_o` is low two cycles after every cycle with `valid_i` low.
- R2: After reset, the first `WIN` output samples are zero.
- R3: Let x[k][i] be the sample at position i (0 to WIN-1) of input window k, counted from reset. For the j-th strobe (0 to WIN-1) of window k+1, the output is computed from window k as follows. Take q = 3j, i = q div 4 and f = q mod 4. The output is floor((x[k][i]·(4−f) + x[k][i+1]·f) / 4).
- R4: Samples at window positions above 3·WIN/4 never affect any output.
- R5: `rst_ni` is asynchronous and active low. While it is low, and in the first cycle after it rises, `valid_o` and `sample_o` are zero. After reset, the window count and the muting of R2 start over.
- R6: While `valid_o` is low, `sample_o` holds the last value it presented.
- R7: Cycles with `valid_i` low advance no pointer. An irregular strobe pattern gives the same output values as back-to-back strobes.
- R8: Full-scale inputs of either sign give exact results per R3, with no wrap-around.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Input sample strobe |
| sample_i | input | DATA_W | Input sample, two's complement |
| valid_o | output | 1 | Output sample strobe |
| sample_o | output | DATA_W | Output sample, two's complement |

## Verification
A rising ramp makes any error in the read position or the interpolation weight visible as a wrong slope or a wrong step. Windows whose last quarter holds full-scale values unlike the rest show whether discarded samples leak into the output. Random data with random idle gaps separates strobe-driven advance from cycle-driven advance. Alternating full-scale values and a reset in the middle of a window expose overflow, rounding of negative values, and restart of the muting.

// File: rtl/pshift_pkg.sv
package pshift_pkg;
  localparam int unsigned FRAC_W = 2;  // quarter-sample read resolution
  localparam int unsigned STEP_Q = 3;  // read advance per output, in quarters
  typedef enum logic {BANK0 = 1'b0, BANK1 = 1'b1} bank_e;
endpackage

// File: rtl/pshift_rd_ctrl.sv
module pshift_rd_ctrl
  import pshift_pkg::*;
#(
  parameter int unsigned WIN = 64,
  localparam int unsigned AW = $clog2(WIN),
  localparam int unsigned ACC_W = AW + FRAC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  output logic [AW-1:0]     wr_addr_o,
  output bank_e             wr_bank_o,
  output logic [AW-1:0]     rd_addr_o,
  output logic [FRAC_W-1:0] frac_o,
  output logic              primed_o
);
  logic [AW-1:0]    wr_idx_q;
  logic [ACC_W-1:0] acc_q;
  bank_e            bank_q;
  logic             primed_q;
  logic             last_w;

  assign last_w = (wr_idx_q == AW'(WIN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_idx_q <= '0;
      acc_q    <= '0;
      bank_q   <= BANK0;
      primed_q <= 1'b0;
    end else if (strobe_i) begin
      wr_idx_q <= wr_idx_q + 1'b1;
      if (last_w) begin
        acc_q    <= '0;
        bank_q   <= (bank_q == BANK0) ? BANK1 : BANK0;
        primed_q <= 1'b1;
      end else begin
        acc_q <= acc_q + ACC_W'(STEP_Q);
      end
    end
  end

  assign wr_addr_o = wr_idx_q;
  assign wr_bank_o = bank_q;
  assign rd_addr_o = acc_q[ACC_W-1:FRAC_W];
  assign frac_o    = acc_q[FRAC_W-1:0];
  assign primed_o  = primed_q;
endmodule

// File: rtl/pshift_win_buf.sv
module pshift_win_buf
  import pshift_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned WIN = 64,
  localparam int unsigned AW = $clog2(WIN)
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  bank_e             wr_bank_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  bank_e             rd_bank_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [DATA_W-1:0] rd_a_o,
  output logic [DATA_W-1:0] rd_b_o
);
  logic [AW-1:0]     rd_addr_nx;
  logic [DATA_W-1:0] bank_a [2];
  logic [DATA_W-1:0] bank_b [2];

  assign rd_addr_nx = rd_addr_i + 1'b1;

  for (genvar g = 0; g < 2; g++) begin : g_bank
    logic [DATA_W-1:0] mem [WIN];
    always_ff @(posedge clk_i) begin
      if (wr_en_i && (wr_bank_i == bank_e'(g))) mem[wr_addr_i] <= wr_data_i;
    end
    assign bank_a[g] = mem[rd_addr_i];
    assign bank_b[g] = mem[rd_addr_nx];
  end

  always_ff @(posedge clk_i) begin
    if (rd_en_i) begin
      rd_a_o <= bank_a[rd_bank_i];
      rd_b_o <= bank_b[rd_bank_i];
    end
  end
endmodule

// File: rtl/pshift_interp.sv
module pshift_interp
  import pshift_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned SW = DATA_W + FRAC_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              mute_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] y_o
);
  logic [FRAC_W:0]   wt_a, wt_b;
  logic signed [SW-1:0] a_x, b_x, sum, shifted;
  logic [DATA_W-1:0] y_w;

  assign wt_b = {1'b0, frac_i};
  assign wt_a = (FRAC_W + 1)'(1 << FRAC_W) - wt_b;
  assign a_x  = {{(SW - DATA_W){a_i[DATA_W-1]}}, a_i};
  assign b_x  = {{(SW - DATA_W){b_i[DATA_W-1]}}, b_i};
  assign sum  = a_x * $signed({1'b0, wt_a}) + b_x * $signed({1'b0, wt_b});
  assign shifted = sum >>> FRAC_W;  // floor
  assign y_w  = mute_i ? '0 : shifted[DATA_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      y_o     <= '0;
    end else begin
      valid_o <= en_i;
      if (en_i) y_o <= y_w;
    end
  end
endmodule

// File: rtl/pshift_down.sv
module pshift_down
  import pshift_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned WIN = 64,
  localparam int unsigned AW = $clog2(WIN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] sample_o
);
  logic [AW-1:0]     wr_addr, rd_addr;
  bank_e             wr_bank, rd_bank;
  logic [FRAC_W-1:0] frac, frac_q;
  logic              primed, mute_q, v1_q;
  logic [DATA_W-1:0] rd_a, rd_b;

  pshift_rd_ctrl #(.WIN(WIN)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (valid_i),
    .wr_addr_o(wr_addr),
    .wr_bank_o(wr_bank),
    .rd_addr_o(rd_addr),
    .frac_o   (frac),
    .primed_o (primed)
  );

  assign rd_bank = (wr_bank == BANK0) ? BANK1 : BANK0;

  pshift_win_buf #(.DATA_W(DATA_W), .WIN(WIN)) u_buf (
    .clk_i    (clk_i),
    .wr_en_i  (valid_i),
    .wr_bank_i(wr_bank),
    .wr_addr_i(wr_addr),
    .wr_data_i(sample_i),
    .rd_en_i  (valid_i),
    .rd_bank_i(rd_bank),
    .rd_addr_i(rd_addr),
    .rd_a_o   (rd_a),
    .rd_b_o   (rd_b)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q   <= 1'b0;
      mute_q <= 1'b1;
      frac_q <= '0;
    end else begin
      v1_q <= valid_i;
      if (valid_i) begin
        mute_q <= !primed;
        frac_q <= frac;
      end
    end
  end

  pshift_interp #(.DATA_W(DATA_W)) u_interp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (v1_q),
    .mute_i (mute_q),
    .a_i    (rd_a),
    .b_i    (rd_b),
    .frac_i (frac_q),
    .valid_o(valid_o),
    .y_o    (sample_o)
  );
endmodule

// File: rtl/pshift_down_chk.sv
module pshift_down_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned WIN = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] sample_o
);
  localparam int unsigned CW = $clog2(WIN) + 1;
  logic [CW-1:0] out_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_cnt_q <= '0;
    else if (valid_o && out_cnt_q < CW'(WIN)) out_cnt_q <= out_cnt_q + 1'b1;
  end

  a_r1_strobe_lat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> ##2 valid_o);
  a_r1_no_extra: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> ##2 !valid_o);
  a_r2_muted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && out_cnt_q < CW'(WIN)) |-> (sample_o == '0));
  a_r5_reset_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!valid_o && sample_o == '0));
  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(sample_o));
endmodule

bind pshift_down pshift_down_chk #(.DATA_W(DATA_W), .WIN(WIN)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .valid_o (valid_o),
  .sample_o(sample_o)
);

// File: tb/pshift_down_tb.sv
module pshift_down_tb;
  localparam int DATA_W = 16;
  localparam int WIN = 64;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic [DATA_W-1:0] sample_i = '0;
  logic valid_o;
  logic [DATA_W-1:0] sample_o;

  int vectors = 0;
  int miscompares = 0;
  int hist[$];
  int n_strobe = 0;
  bit d1_v, d2_v;
  int d1_y, d2_y, d1_n, d2_n;
  int last_y = 0;
  string tag = "R5";
  bit done = 0;

  always #5 clk_i = ~clk_i;

  pshift_down #(.DATA_W(DATA_W), .WIN(WIN)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .sample_i(sample_i),
    .valid_o(valid_o), .sample_o(sample_o)
  );

  function automatic int model(int n);
    int m, j, q, i, f, a, b;
    if (n < WIN) return 0;
    m = n / WIN - 1;
    j = n % WIN;
    q = 3 * j;
    i = q / 4;
    f = q % 4;
    a = hist[m * WIN + i];
    b = hist[m * WIN + i + 1];
    return (a * (4 - f) + b * f) >>> 2;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // one clock: compare outputs, then drive the next input
  task automatic step(bit v, int s);
    @(negedge clk_i);
    check(valid_o == d2_v, "R1", int'(valid_o), int'(d2_v));
    if (d2_v) begin
      check($signed(sample_o) == d2_y, (d2_n < WIN) ? "R2" : tag,
            $signed(sample_o), d2_y);
      last_y = d2_y;
    end else begin
      check($signed(sample_o) == last_y, "R6", $signed(sample_o), last_y);
    end
    d2_v = d1_v; d2_y = d1_y; d2_n = d1_n;
    valid_i = v;
    sample_i = DATA_W'(s);
    d1_v = v;
    if (v) begin
      hist.push_back(s);
      d1_y = model(n_strobe);
      d1_n = n_strobe;
      n_strobe++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    valid_i = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i);
      check(!valid_o && sample_o == '0, "R5", int'(sample_o), 0);
    end
    hist.delete();
    n_strobe = 0;
    d1_v = 0; d2_v = 0; d1_y = 0; d2_y = 0; d1_n = 0; d2_n = 0;
    last_y = 0;
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      miscompares++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    tag = "R5";
    do_reset();
    step(0, 0);
    step(0, 0);
    // ramp, back to back
    tag = "R3";
    for (int k = 0; k < 3 * WIN; k++) step(1, k * 37 - 3000);
    // random data with idle gaps
    tag = "R7";
    for (int k = 0; k < 3 * WIN; k++) begin
      int gaps = $urandom_range(0, 2);
      for (int g = 0; g < gaps; g++) step(0, 0);
      step(1, int'($signed(16'($urandom))));
    end
    // discarded tail holds full scale garbage
    tag = "R4";
    for (int k = 0; k < 3 * WIN; k++) begin
      int pos = k % WIN;
      if (pos > 3 * WIN / 4) step(1, ((k & 1) != 0) ? 32767 : -32768);
      else step(1, pos * 11 - 200);
    end
    // alternating full scale
    tag = "R8";
    for (int k = 0; k < 2 * WIN; k++)
      step(1, ((k & 1) != 0) ? 32767 : -32768);
    // reset mid window, muting restarts
    for (int k = 0; k < WIN / 2; k++) step(1, 1000 + k);
    tag = "R5";
    do_reset();
    for (int k = 0; k < 2 * WIN + 5; k++) step(1, 500 - 9 * k);
    for (int k = 0; k < 4; k++) step(0, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule